// File: doc/BRIEF.md
# Secure Scan Chain Controller

This block holds the scan-testable key register and data register that sit at the front of a cipher datapath, and keeps the secret key from leaking through the scan chain. Both registers form one serial chain. A tester enters it at `scan_in` and leaves it at `scan_out`. The block enforces three protections. First, the chain is wiped on the clock edge at which the test-mode pin changes, in either direction. Second, the "load external key" select code is turned into "hold" while test mode is active. Third, scan shifting is refused in functional mode.

Mode-change detection costs one extra flip-flop and an XOR. The resulting pulse joins the system reset on the registers' synchronous clear, so no added input pin is needed. Test application needs no extra cycles. The price is that the chain cannot be scanned while the part is running functionally.

Chain order, from input to output: `scan_in` enters at data bit DATA_W-1. The chain then runs down to data bit 0, passes into key bit KEY_W-1, runs down to key bit 0, and key bit 0 drives `scan_out`. The key is therefore unloaded LSB first.

Top module: `secure_scan_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both registers are cleared to zero, so `key_out`, `data_out` and `scan_out` read 0 afterwards.
- R2: At any clock edge where `test_mode` differs from its value at the previous edge (0→1 or 1→0), both registers are cleared to zero, whatever the other inputs are. A full unload of the chain after entering test mode therefore shifts out only zeros.
- R3: In test mode, key select code 2'b00 (load external key) is treated as 2'b11 (hold), so `key_in` never reaches the key register. Codes 2'b01, 2'b10 and 2'b11 are not remapped.
- R4: In functional mode, code 2'b00 loads `key_in` into the key register.
- R5: Code 2'b01 loads the round-key update bus `rkey_in` into the key register, in either mode.
- R6: Code 2'b11 keeps the key register unchanged.
- R7: In test mode with `scan_en` high, the data register takes `{scan_in, data_out[DATA_W-1:1]}`. If the key code is 2'b10, the key register takes `{data_out[0], key_out[KEY_W-1:1]}` in the same edge. `scan_out` always equals `key_out[0]`.
- R8: In functional mode `scan_en` has no effect, and key code 2'b10 holds the key register.
- R9: Whenever the block is not shifting (functional mode, or `scan_en` low), the data register loads `data_in` at each edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 = test mode, 0 = functional mode; synchronous to `clk` |
| scan_en | input | 1 | Scan shift request (honoured only in test mode) |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (key bit 0) |
| key_sel | input | 2 | Key input select: 00 external key, 01 round key, 10 scan path, 11 hold |
| key_in | input | KEY_W | External (secret) key bus |
| rkey_in | input | KEY_W | Round-key update bus from the cipher |
| data_in | input | DATA_W | Data input bus |
| key_out | output | KEY_W | Key register contents to the cipher |
| data_out | output | DATA_W | Data register contents to the cipher |

## Verification
The assertions assume that `test_mode` is a clean synchronous level: it is sampled only at clock edges and never glitches between them. They also assume `rst` is held high from time zero until the first edges have passed. The bench drives every input just after a rising edge and keeps `rst` high for its first cycles. It changes `test_mode` only at those drive points, both in directed switches and in a seeded random phase. The mode-dependent properties look only at cycles where the mode is steady across two edges. The mode-change property owns the switching edges.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  // Key register input paths, encoded as the raw select code.
  typedef enum logic [1:0] {
    KSEL_EXT   = 2'b00,
    KSEL_ROUND = 2'b01,
    KSEL_SHIFT = 2'b10,
    KSEL_HOLD  = 2'b11
  } ksel_e;
endpackage

// File: rtl/ssc_mode_watch.sv
module ssc_mode_watch (
  input  logic clk,
  input  logic rst,
  input  logic test_mode,
  output logic clr
);
  // Single added flop: last sampled mode.
  logic tm_q;

  always_ff @(posedge clk) begin
    tm_q <= test_mode;
  end

  // One-cycle pulse on any mode change, merged with system reset.
  always_comb begin
    clr = rst | (tm_q ^ test_mode);
  end
endmodule

// File: rtl/ssc_sel_remap.sv
module ssc_sel_remap
  import ssc_pkg::*;
(
  input  logic [1:0] sel_raw,
  input  logic       test_mode,
  output ksel_e      sel_eff
);
  always_comb begin
    if (test_mode && (sel_raw == 2'b00)) begin
      sel_eff = KSEL_HOLD;
    end else begin
      sel_eff = ksel_e'(sel_raw);
    end
  end
endmodule

// File: rtl/ssc_chain.sv
module ssc_chain
  import ssc_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              shift,
  input  ksel_e             sel_eff,
  input  logic              scan_in,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [KEY_W-1:0]  rkey_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [KEY_W-1:0]  key_q,
  output logic [DATA_W-1:0] data_q,
  output logic              scan_out
);
  logic [KEY_W-1:0]  key_nx;
  logic [DATA_W-1:0] data_nx;
  logic [DATA_W:0]   dlink;
  logic [KEY_W:0]    klink;

  // Serial links: dlink[i+1] feeds data cell i, klink[j+1] feeds key cell j.
  assign dlink[DATA_W] = scan_in;
  assign klink[KEY_W]  = dlink[0];
  assign scan_out      = klink[0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_dcell
    assign dlink[i]   = data_q[i];
    assign data_nx[i] = shift ? dlink[i+1] : data_in[i];
  end

  for (genvar j = 0; j < KEY_W; j++) begin : g_kcell
    assign klink[j] = key_q[j];
    always_comb begin
      unique case (sel_eff)
        KSEL_EXT:   key_nx[j] = key_in[j];
        KSEL_ROUND: key_nx[j] = rkey_in[j];
        KSEL_SHIFT: key_nx[j] = shift ? klink[j+1] : key_q[j];
        default:    key_nx[j] = key_q[j];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      key_q  <= '0;
      data_q <= '0;
    end else begin
      key_q  <= key_nx;
      data_q <= data_nx;
    end
  end
endmodule

// File: rtl/secure_scan_ctrl.sv
module secure_scan_ctrl
  import ssc_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_mode,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [1:0]        key_sel,
  input  logic [KEY_W-1:0]  key_in,
  input  logic [KEY_W-1:0]  rkey_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [KEY_W-1:0]  key_out,
  output logic [DATA_W-1:0] data_out
);
  logic  clr;
  logic  shift_ok;
  ksel_e sel_eff;

  // Shifting is only honoured in test mode.
  assign shift_ok = scan_en & test_mode;

  ssc_mode_watch u_watch (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .clr       (clr)
  );

  ssc_sel_remap u_remap (
    .sel_raw   (key_sel),
    .test_mode (test_mode),
    .sel_eff   (sel_eff)
  );

  ssc_chain #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_chain (
    .clk      (clk),
    .clr      (clr),
    .shift    (shift_ok),
    .sel_eff  (sel_eff),
    .scan_in  (scan_in),
    .key_in   (key_in),
    .rkey_in  (rkey_in),
    .data_in  (data_in),
    .key_q    (key_out),
    .data_q   (data_out),
    .scan_out (scan_out)
  );
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int KEY_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              test_mode,
  input logic              scan_en,
  input logic              scan_in,
  input logic [1:0]        key_sel,
  input logic [KEY_W-1:0]  key_in,
  input logic [DATA_W-1:0] data_in,
  input logic [KEY_W-1:0]  key_out,
  input logic [DATA_W-1:0] data_out
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (key_out == '0) && (data_out == '0)); // R1

  AST_MODE_SWITCH_WIPE: assert property (@(posedge clk) disable iff (rst)
    (test_mode != $past(test_mode)) |=> (key_out == '0) && (data_out == '0)); // R2

  AST_TEST_NO_KEY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (test_mode && $past(test_mode) && key_sel == 2'b00) |=> $stable(key_out)); // R3

  AST_FUNC_KEY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !$past(test_mode) && key_sel == 2'b00) |=> key_out == $past(key_in)); // R4

  AST_TEST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (test_mode && $past(test_mode) && scan_en)
      |=> data_out == {$past(scan_in), $past(data_out[DATA_W-1:1])}); // R7

  AST_FUNC_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !$past(test_mode) && scan_en && key_sel == 2'b10) |=> $stable(key_out)); // R8

  AST_CAPTURE_DATA: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && test_mode == $past(test_mode)) |=> data_out == $past(data_in)); // R9
endmodule

bind secure_scan_ctrl ssc_checker #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .test_mode (test_mode),
  .scan_en   (scan_en),
  .scan_in   (scan_in),
  .key_sel   (key_sel),
  .key_in    (key_in),
  .data_in   (data_in),
  .key_out   (key_out),
  .data_out  (data_out)
);

// File: tb/sim_secure_scan_ctrl.sv
`timescale 1ns/1ps
module sim_secure_scan_ctrl;
  localparam int KW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          test_mode = 1'b0;
  logic          scan_en = 1'b0;
  logic          scan_in = 1'b0;
  logic [1:0]    key_sel = 2'b11;
  logic [KW-1:0] key_in = '0;
  logic [KW-1:0] rkey_in = '0;
  logic [DW-1:0] data_in = '0;
  logic          scan_out;
  logic [KW-1:0] key_out;
  logic [DW-1:0] data_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Expected state, built from the requirements.
  logic [KW-1:0] ek = '0;
  logic [DW-1:0] ed = '0;
  logic          tm_prev = 1'b0;

  always #2.5 clk = ~clk;

  secure_scan_ctrl #(.KEY_W(KW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .test_mode(test_mode), .scan_en(scan_en),
    .scan_in(scan_in), .scan_out(scan_out), .key_sel(key_sel),
    .key_in(key_in), .rkey_in(rkey_in), .data_in(data_in),
    .key_out(key_out), .data_out(data_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of();
    if (rst) return "R1";
    if (test_mode != tm_prev) return "R2";
    if (test_mode && key_sel == 2'b00) return "R3";
    if (!test_mode && key_sel == 2'b00) return "R4";
    if (key_sel == 2'b01) return "R5";
    if (key_sel == 2'b11) return "R6";
    if (test_mode && scan_en) return "R7";
    return "R8";
  endfunction

  // Advance the expectation by one edge (inputs as currently driven).
  task automatic predict();
    logic sh;
    logic [KW-1:0] nk;
    logic [DW-1:0] nd;
    if (rst || test_mode != tm_prev) begin
      nk = '0;
      nd = '0;
    end else begin
      sh = test_mode & scan_en;
      case (key_sel)
        2'b00: nk = test_mode ? ek : key_in;
        2'b01: nk = rkey_in;
        2'b10: nk = sh ? {ed[0], ek[KW-1:1]} : ek;
        default: nk = ek;
      endcase
      nd = sh ? {scan_in, ed[DW-1:1]} : data_in;
    end
    ek = nk;
    ed = nd;
    tm_prev = test_mode;
  endtask

  // One edge, then compare all outputs against the expectation.
  task automatic step();
    string t;
    t = tag_of();
    predict();
    @(posedge clk);
    #1;
    chk(key_out == ek, {t, " key_out"}, key_out, ek);
    chk(data_out == ed, (t == "R7" || t == "R1" || t == "R2") ? {t, " data_out"} : "R9 data_out",
        data_out, ed);
    chk(scan_out == ek[0], "R7 scan_out", scan_out, ek[0]);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step();
    step();
    chk(key_out == 0 && data_out == 0 && scan_out == 0, "R1 reset", key_out, 0);
    rst = 1'b0;

    // Sweep both modes, all codes, scan_en and scan_in values.
    for (int m = 0; m < 2; m++) begin
      test_mode = m[0];
      step();  // mode edge (R2) or settle
      for (int k = 0; k < 4; k++) begin
        for (int s = 0; s < 4; s++) begin
          key_sel = k[1:0];
          scan_en = s[0];
          scan_in = s[1];
          key_in  = KW'(8'h3C ^ (k * 37 + s * 11 + m * 90));
          rkey_in = KW'(8'hC5 + k * 13 + s * 7);
          data_in = DW'(8'h5A ^ (s * 29 + k * 3));
          step();
        end
      end
    end

    // Directed: load key in functional mode (R4), then enter test mode (R2).
    test_mode = 1'b0; scan_en = 1'b0; key_sel = 2'b00; key_in = 8'hA5;
    step(); step();
    chk(key_out == 8'hA5, "R4 key loaded", key_out, 8'hA5);
    key_sel = 2'b10; scan_en = 1'b1; test_mode = 1'b1;
    step();
    chk(key_out == 0 && data_out == 0, "R2 wipe on entry", key_out, 0);
    for (int i = 0; i < KW + DW; i++) begin
      scan_in = 1'b0;
      chk(scan_out == 1'b0, "R2 unload zero", scan_out, 0);
      step();
    end

    // R3: load attempt in test mode leaves the register unchanged.
    scan_en = 1'b0; key_sel = 2'b01; rkey_in = 8'h96;
    step();
    key_sel = 2'b00; key_in = 8'h0F;
    step(); step();
    chk(key_out == 8'h96, "R3 key unchanged", key_out, 8'h96);

    // R7: unload the key LSB first.
    key_sel = 2'b10; scan_en = 1'b1;
    for (int i = 0; i < KW; i++) begin
      logic b;
      b = (8'h96 >> i) & 1;
      chk(scan_out == b, "R7 key stream", scan_out, b);
      step();
    end

    // Back to functional (R2), then scan_en must be ignored (R8).
    key_sel = 2'b00; key_in = 8'h77; test_mode = 1'b0;
    step();
    chk(key_out == 0 && data_out == 0, "R2 wipe on exit", key_out, 0);
    step();
    key_sel = 2'b10; scan_en = 1'b1; data_in = 8'h12;
    for (int i = 0; i < 4; i++) begin
      scan_in = i[0];
      step();
    end
    chk(key_out == 8'h77, "R8 no shift in functional", key_out, 8'h77);
    chk(data_out == 8'h12, "R9 capture in functional", data_out, 8'h12);

    // Seeded random phase with occasional mode flips.
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'h0) test_mode = ~test_mode;
      scan_en = r[4];
      scan_in = r[5];
      key_sel = r[7:6];
      key_in  = r[15:8];
      rkey_in = r[23:16];
      data_in = r[31:24];
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule